// File: doc/BRIEF.md
# Clock-Calendar Counter

This block keeps wall-clock time and date for a chip that already has a one-pulse-per-second enable, derived from a 32.768 kHz divider chain. On each qualified pulse it advances seconds, minutes and hours, then the day of week, the day of month, the month and a two-digit year. Carries ripple from one field to the next inside the same clock edge. Every byte is held in one of two encodings, chosen at run time: plain binary or packed BCD. Hours run in either a 24-hour or a 12-hour scheme. The 12-hour scheme keeps an afternoon flag in the top bit of the hours byte.

Software reaches the ten time and alarm bytes through a simple register-file port. It can freeze the advance while it rewrites a consistent time. An optional daylight-saving rule moves the clock forward one hour in spring and back one hour in autumn. After every completed advance the block raises a one-cycle update pulse. When the new time matches the three alarm bytes it also raises an alarm pulse. An alarm byte can be made a wildcard, so the alarm can repeat anywhere from every second to once a day.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the registers read as follows. Index 0 (seconds), 1 (minutes), 2 (hours) and 6 (year) read 0. Index 3 (day of week, 1 = Sunday … 7), 4 (day of month) and 5 (month) read 1. Indices 7, 8 and 9 are the seconds, minutes and hours alarm bytes and read 0. Both pulses are low.
- R2: With cfg_bin=0 (BCD), each advance increments the seconds. A low digit of 9 carries into the high digit, so 0x09 becomes 0x10. The time 23:59:59 in 24-hour mode becomes 00:00:00, and the day of week and the day of month advance.
- R3: With cfg_bin=1 the same counting happens in plain binary. Seconds 0x09 become 0x0A. 23:59:59 (0x17:0x3B:0x3B) on day 30 of month 4 becomes 00:00:00 on day 1 of month 5.
- R4: With cfg_24h=0, hours bit 7 is the afternoon flag and bits 6:0 hold 1..12. 11:59:59 in the morning becomes 12 with the flag set (BCD 0x92). 0x92 becomes 0x81. 11:59:59 in the afternoon (0x91) becomes 0x12, and the date advances.
- R5: Months have 30 or 31 days; February has 29 when the year is a multiple of 4 and 28 otherwise. Year 99 wraps to 00 after 31 December.
- R6: The day of week runs 1..7 and wraps from 7 to 1.
- R7: While cfg_set=1, a tick changes no time byte and produces no update pulse.
- R8: Seconds bit 7 cannot be written; a write of 0xC5 reads back as 0x45.
- R9: A register write in the same cycle as a tick takes priority. That tick is dropped: no field advances and no update pulse follows.
- R10: update_pulse is high for exactly the one cycle that follows the edge which loaded the advanced time.
- R11: alarm_pulse rises together with update_pulse when the new seconds, minutes and hours equal the alarm bytes. An alarm byte whose bits 7:6 are both 1 matches any value.
- R12: With cfg_dst=1 the daylight-saving rule applies on a Sunday at 01:59:59. In April, on days 1..7, the time goes to 03:00:00. In October, on days 25 and later, it goes to 01:00:00 once, and the next 01:59:59 goes on to 02:00:00. With cfg_dst=0 no jump occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle advance request, once per second |
| cfg_bin | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| cfg_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with afternoon flag |
| cfg_dst | input | 1 | Enables the daylight-saving rule |
| cfg_set | input | 1 | Freezes the advance |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| update_pulse | output | 1 | One cycle after each advance |
| alarm_pulse | output | 1 | One cycle, with update_pulse, on an alarm match |

## Verification
Two functions can meet in one cycle: a software write and a second tick. The bench provokes this by raising reg_we and tick_1hz on the same falling edge, with the write aimed at the minutes byte. It then judges the outcome at the next falling edge. The minutes must hold the written value, the seconds must be unchanged, and update_pulse must stay low. A second overlap is an alarm match landing on the same advance as the update pulse. The bench checks that both pulses are sampled high together in that one cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // register indices (alarm bytes follow the calendar bytes)
   localparam int unsigned IX_SEC   = 0;
   localparam int unsigned IX_MIN   = 1;
   localparam int unsigned IX_HOUR  = 2;
   localparam int unsigned IX_WDAY  = 3;
   localparam int unsigned IX_MDAY  = 4;
   localparam int unsigned IX_MON   = 5;
   localparam int unsigned IX_YEAR  = 6;
   localparam int unsigned IX_ASEC  = 7;
   localparam int unsigned IX_AMIN  = 8;
   localparam int unsigned IX_AHOUR = 9;

   // integer value to stored encoding
   function automatic byte_t to_fmt(input byte_t n, input logic bin);
      byte_t tens, ones;
      tens = n / 8'd10;
      ones = n % 8'd10;
      return bin ? n : {tens[3:0], ones[3:0]};
   endfunction

   // stored encoding to integer value
   function automatic byte_t from_fmt(input byte_t v, input logic bin);
      return bin ? v : (({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]});
   endfunction

   // add one in the stored encoding
   function automatic byte_t fmt_inc(input byte_t v, input logic bin);
      if (bin || v[3:0] < 4'd9) return v + 8'd1;
      return {v[7:4] + 4'd1, 4'd0};
   endfunction
endpackage

// File: rtl/rtc_wrap_inc.sv
module rtc_wrap_inc
   import rtc_cal_pkg::*;
(
   input  byte_t cur,
   input  byte_t lo,
   input  byte_t hi,
   input  logic  bin,
   output byte_t nxt,
   output logic  wrap
);
   byte_t cur_val;

   always_comb begin
      cur_val = from_fmt(cur, bin);
      wrap    = (cur_val >= hi);
      nxt     = wrap ? to_fmt(lo, bin) : fmt_inc(cur, bin);
   end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
   import rtc_cal_pkg::*;
(
   input  byte_t cur,
   input  logic  bin,
   input  logic  h24,
   output byte_t nxt,
   output logic  day_wrap
);
   byte_t nxt24, hv, low_inc;
   logic  wrap24;
   byte_t one_enc, twelve_enc;

   rtc_wrap_inc u_h24 (
      .cur  (cur),
      .lo   (8'd0),
      .hi   (8'd23),
      .bin  (bin),
      .nxt  (nxt24),
      .wrap (wrap24)
   );

   always_comb begin
      hv         = from_fmt({1'b0, cur[6:0]}, bin);
      low_inc    = fmt_inc({1'b0, cur[6:0]}, bin);
      one_enc    = to_fmt(8'd1, bin);
      twelve_enc = to_fmt(8'd12, bin);
      if (h24) begin
         nxt      = nxt24;
         day_wrap = wrap24;
      end else if (hv >= 8'd12) begin
         nxt      = {cur[7], one_enc[6:0]};
         day_wrap = 1'b0;
      end else if (hv == 8'd11) begin
         nxt      = {~cur[7], twelve_enc[6:0]};
         day_wrap = cur[7];
      end else begin
         nxt      = {cur[7], low_inc[6:0]};
         day_wrap = 1'b0;
      end
   end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_cal_pkg::*;
#(
   parameter int unsigned FIELDS = 3
) (
   input  logic [FIELDS*BYTE_W-1:0] now_flat,
   input  logic [FIELDS*BYTE_W-1:0] alm_flat,
   output logic                     match
);
   logic [FIELDS-1:0] field_ok;

   for (genvar i = 0; i < FIELDS; i++) begin : g_field
      byte_t now_b, alm_b;
      assign now_b       = now_flat[i*BYTE_W +: BYTE_W];
      assign alm_b       = alm_flat[i*BYTE_W +: BYTE_W];
      assign field_ok[i] = (alm_b[7:6] == 2'b11) || (alm_b == now_b);
   end

   assign match = &field_ok;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WEEK_DAYS  = 7,
   parameter int unsigned YEAR_LAST  = 99,
   parameter int unsigned LEAP_EVERY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              cfg_bin,
   input  logic              cfg_24h,
   input  logic              cfg_dst,
   input  logic              cfg_set,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              update_pulse,
   output logic              alarm_pulse
);
   localparam int unsigned ALM_N     = 3;
   localparam int unsigned NUM_REGS  = 7 + ALM_N;
   localparam byte_t       LEAP_MASK = byte_t'(LEAP_EVERY - 1);

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("rtc_calendar: DATA_W must be 8");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("rtc_calendar: ADDR_W too small for register set");
   end
   if ((LEAP_EVERY & (LEAP_EVERY - 1)) != 0) begin : g_bad_leap
      $error("rtc_calendar: LEAP_EVERY must be a power of two");
   end

   byte_t sec_q, min_q, hr_q, wday_q, mday_q, mon_q, year_q;
   byte_t asec_q, amin_q, ahr_q;
   logic  fall_done_q;

   byte_t sec_nx, min_nx, hr_nx, wday_nx, mday_nx, mon_nx, year_nx;
   logic  sec_w, min_w, hr_w, wday_w, mday_w, mon_w, year_w;
   byte_t n_sec, n_min, n_hr, n_wday, n_mday, n_mon, n_year;
   byte_t mon_b, year_b, mday_b, dim;
   logic  advance, leap, carry_h, carry_d, carry_m, carry_y;
   logic  dst_hit, spring, fall, alarm_hit;

   assign advance = tick_1hz & ~cfg_set & ~reg_we;

   rtc_wrap_inc u_sec  (.cur(sec_q),  .lo(8'd0), .hi(8'd59), .bin(cfg_bin), .nxt(sec_nx),  .wrap(sec_w));
   rtc_wrap_inc u_min  (.cur(min_q),  .lo(8'd0), .hi(8'd59), .bin(cfg_bin), .nxt(min_nx),  .wrap(min_w));
   rtc_wrap_inc u_wday (.cur(wday_q), .lo(8'd1), .hi(byte_t'(WEEK_DAYS)), .bin(cfg_bin),
                        .nxt(wday_nx), .wrap(wday_w));
   rtc_wrap_inc u_mday (.cur(mday_q), .lo(8'd1), .hi(dim), .bin(cfg_bin), .nxt(mday_nx), .wrap(mday_w));
   rtc_wrap_inc u_mon  (.cur(mon_q),  .lo(8'd1), .hi(8'd12), .bin(cfg_bin), .nxt(mon_nx), .wrap(mon_w));
   rtc_wrap_inc u_year (.cur(year_q), .lo(8'd0), .hi(byte_t'(YEAR_LAST)), .bin(cfg_bin),
                        .nxt(year_nx), .wrap(year_w));

   rtc_hour_step u_hour (
      .cur      (hr_q),
      .bin      (cfg_bin),
      .h24      (cfg_24h),
      .nxt      (hr_nx),
      .day_wrap (hr_w)
   );

   // month length from the current month and year
   always_comb begin
      mon_b  = from_fmt(mon_q, cfg_bin);
      year_b = from_fmt(year_q, cfg_bin);
      mday_b = from_fmt(mday_q, cfg_bin);
      leap   = ((year_b & LEAP_MASK) == 8'd0);
      case (mon_b)
         8'd2:                    dim = leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11: dim = 8'd30;
         default:                 dim = 8'd31;
      endcase
   end

   // carry chain and daylight-saving override
   always_comb begin
      carry_h = sec_w & min_w;
      carry_d = carry_h & hr_w;
      carry_m = carry_d & mday_w;
      carry_y = carry_m & mon_w;
      dst_hit = cfg_dst & carry_h & (hr_q == 8'h01) & (wday_q == 8'h01);
      spring  = dst_hit & (mon_b == 8'd4) & (mday_b <= 8'd7);
      fall    = dst_hit & (mon_b == 8'd10) & (mday_b >= 8'd25) & ~fall_done_q;
      n_sec   = sec_nx;
      n_min   = sec_w ? min_nx : min_q;
      n_hr    = carry_h ? hr_nx : hr_q;
      if (spring) n_hr = 8'h03;
      if (fall)   n_hr = 8'h01;
      n_wday  = carry_d ? wday_nx : wday_q;
      n_mday  = carry_d ? mday_nx : mday_q;
      n_mon   = carry_m ? mon_nx : mon_q;
      n_year  = carry_y ? year_nx : year_q;
   end

   rtc_alarm_cmp #(.FIELDS(ALM_N)) u_alarm (
      .now_flat ({n_hr, n_min, n_sec}),
      .alm_flat ({ahr_q, amin_q, asec_q}),
      .match    (alarm_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q        <= 8'd0;
         min_q        <= 8'd0;
         hr_q         <= 8'd0;
         wday_q       <= 8'd1;
         mday_q       <= 8'd1;
         mon_q        <= 8'd1;
         year_q       <= 8'd0;
         asec_q       <= 8'd0;
         amin_q       <= 8'd0;
         ahr_q        <= 8'd0;
         fall_done_q  <= 1'b0;
         update_pulse <= 1'b0;
         alarm_pulse  <= 1'b0;
      end else begin
         update_pulse <= advance;
         alarm_pulse  <= advance & alarm_hit;
         if (advance && fall)    fall_done_q <= 1'b1;
         else if (hr_q != 8'h01) fall_done_q <= 1'b0;
         if (reg_we) begin
            case (reg_addr)
               ADDR_W'(IX_SEC):   sec_q  <= {1'b0, reg_wdata[6:0]};
               ADDR_W'(IX_MIN):   min_q  <= reg_wdata;
               ADDR_W'(IX_HOUR):  hr_q   <= reg_wdata;
               ADDR_W'(IX_WDAY):  wday_q <= reg_wdata;
               ADDR_W'(IX_MDAY):  mday_q <= reg_wdata;
               ADDR_W'(IX_MON):   mon_q  <= reg_wdata;
               ADDR_W'(IX_YEAR):  year_q <= reg_wdata;
               ADDR_W'(IX_ASEC):  asec_q <= reg_wdata;
               ADDR_W'(IX_AMIN):  amin_q <= reg_wdata;
               ADDR_W'(IX_AHOUR): ahr_q  <= reg_wdata;
               default: ;
            endcase
         end else if (advance) begin
            sec_q  <= n_sec;
            min_q  <= n_min;
            hr_q   <= n_hr;
            wday_q <= n_wday;
            mday_q <= n_mday;
            mon_q  <= n_mon;
            year_q <= n_year;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_W'(IX_SEC):   reg_rdata = sec_q;
         ADDR_W'(IX_MIN):   reg_rdata = min_q;
         ADDR_W'(IX_HOUR):  reg_rdata = hr_q;
         ADDR_W'(IX_WDAY):  reg_rdata = wday_q;
         ADDR_W'(IX_MDAY):  reg_rdata = mday_q;
         ADDR_W'(IX_MON):   reg_rdata = mon_q;
         ADDR_W'(IX_YEAR):  reg_rdata = year_q;
         ADDR_W'(IX_ASEC):  reg_rdata = asec_q;
         ADDR_W'(IX_AMIN):  reg_rdata = amin_q;
         ADDR_W'(IX_AHOUR): reg_rdata = ahr_q;
         default:           reg_rdata = '0;
      endcase
   end

   // R8
   sec_msb_chk: assert property (@(posedge clk) disable iff (!rst_n) sec_q[7] == 1'b0);

   // R7
   set_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_set && !reg_we) |=> ($stable({hr_q, min_q, sec_q}) && !update_pulse));

   // R10
   upd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_pulse |-> $past(tick_1hz && !cfg_set && !reg_we));

   // R11
   alarm_with_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> update_pulse);

   // R9
   wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && tick_1hz) |=> !update_pulse);
endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_SEC = 4'd0, A_MIN = 4'd1, A_HR = 4'd2, A_WDAY = 4'd3,
                          A_MDAY = 4'd4, A_MON = 4'd5, A_YEAR = 4'd6,
                          A_ASEC = 4'd7, A_AMIN = 4'd8, A_AHR = 4'd9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       cfg_bin = 1'b0, cfg_24h = 1'b1, cfg_dst = 1'b0, cfg_set = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = 4'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       update_pulse, alarm_pulse;
   int         n_tests = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_calendar u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .cfg_bin(cfg_bin),
      .cfg_24h(cfg_24h), .cfg_dst(cfg_dst), .cfg_set(cfg_set), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .update_pulse(update_pulse), .alarm_pulse(alarm_pulse)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic chk_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   // tick; returns at the falling edge after the advancing edge
   task automatic tick1();
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      wr(A_HR, h); wr(A_MIN, m); wr(A_SEC, s);
   endtask

   task automatic set_dmy(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
      wr(A_MDAY, d); wr(A_MON, mo); wr(A_YEAR, y);
   endtask

   task automatic t_reset();
      chk_reg("R1 sec", A_SEC, 8'h00);  chk_reg("R1 min", A_MIN, 8'h00);
      chk_reg("R1 hour", A_HR, 8'h00);  chk_reg("R1 wday", A_WDAY, 8'h01);
      chk_reg("R1 mday", A_MDAY, 8'h01); chk_reg("R1 mon", A_MON, 8'h01);
      chk_reg("R1 year", A_YEAR, 8'h00); chk_reg("R1 asec", A_ASEC, 8'h00);
      chk_reg("R1 amin", A_AMIN, 8'h00); chk_reg("R1 ahour", A_AHR, 8'h00);
      chk("R1 update", {7'd0, update_pulse}, 8'h00);
      chk("R1 alarm", {7'd0, alarm_pulse}, 8'h00);
   endtask

   task automatic t_bcd_roll();
      cfg_bin = 1'b0; cfg_24h = 1'b1;
      wr(A_SEC, 8'h09);
      tick1();
      chk("R10 pulse high", {7'd0, update_pulse}, 8'h01);
      chk_reg("R2 digit carry", A_SEC, 8'h10);
      @(negedge clk);
      chk("R10 pulse one cycle", {7'd0, update_pulse}, 8'h00);
      wr(A_WDAY, 8'h07);
      set_dmy(8'h15, 8'h06, 8'h24);
      set_hms(8'h23, 8'h59, 8'h59);
      tick1();
      chk_reg("R2 sec", A_SEC, 8'h00); chk_reg("R2 min", A_MIN, 8'h00);
      chk_reg("R2 hour", A_HR, 8'h00); chk_reg("R2 mday", A_MDAY, 8'h16);
      chk_reg("R6 wday wrap", A_WDAY, 8'h01);
   endtask

   task automatic t_binary();
      cfg_bin = 1'b1;
      wr(A_SEC, 8'h09);
      tick1();
      chk_reg("R3 bin sec", A_SEC, 8'h0A);
      set_dmy(8'd30, 8'd4, 8'd24);
      set_hms(8'd23, 8'd59, 8'd59);
      tick1();
      chk_reg("R3 bin hour", A_HR, 8'h00); chk_reg("R3 bin mday", A_MDAY, 8'h01);
      chk_reg("R3 bin mon", A_MON, 8'h05);
      cfg_bin = 1'b0;
   endtask

   task automatic t_12h();
      cfg_24h = 1'b0;
      set_dmy(8'h10, 8'h03, 8'h21);
      set_hms(8'h11, 8'h59, 8'h59);
      tick1();
      chk_reg("R4 noon", A_HR, 8'h92);
      set_hms(8'h92, 8'h59, 8'h59);
      tick1();
      chk_reg("R4 one pm", A_HR, 8'h81);
      set_hms(8'h91, 8'h59, 8'h59);
      tick1();
      chk_reg("R4 midnight", A_HR, 8'h12);
      chk_reg("R4 date adv", A_MDAY, 8'h11);
      cfg_24h = 1'b1;
   endtask

   task automatic roll_day(input string tag, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y, input logic [7:0] ed, input logic [7:0] em,
                           input logic [7:0] ey);
      set_dmy(d, mo, y);
      set_hms(8'h23, 8'h59, 8'h59);
      tick1();
      chk_reg(tag, A_MDAY, ed); chk_reg(tag, A_MON, em); chk_reg(tag, A_YEAR, ey);
   endtask

   task automatic t_calendar();
      roll_day("R5 feb28 common", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
      roll_day("R5 feb28 leap",   8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
      roll_day("R5 feb29 leap",   8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
      roll_day("R5 apr30",        8'h30, 8'h04, 8'h24, 8'h01, 8'h05, 8'h24);
      roll_day("R5 jan30",        8'h30, 8'h01, 8'h24, 8'h31, 8'h01, 8'h24);
      roll_day("R5 year wrap",    8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
   endtask

   task automatic t_set_freeze();
      wr(A_SEC, 8'h10);
      cfg_set = 1'b1;
      tick1();
      chk("R7 no pulse", {7'd0, update_pulse}, 8'h00);
      chk_reg("R7 frozen", A_SEC, 8'h10);
      cfg_set = 1'b0;
   endtask

   task automatic t_sec_ro();
      wr(A_SEC, 8'hC5);
      chk_reg("R8 msb ro", A_SEC, 8'h45);
   endtask

   task automatic t_collision();
      wr(A_SEC, 8'h20);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = A_MIN; reg_wdata = 8'h33; tick_1hz = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; tick_1hz = 1'b0;
      chk("R9 no pulse", {7'd0, update_pulse}, 8'h00);
      chk_reg("R9 sec held", A_SEC, 8'h20);
      chk_reg("R9 min written", A_MIN, 8'h33);
   endtask

   task automatic t_alarm();
      wr(A_ASEC, 8'h30); wr(A_AMIN, 8'hC0); wr(A_AHR, 8'hFF);
      wr(A_SEC, 8'h29);
      tick1();
      chk("R11 wildcard hit", {6'd0, alarm_pulse, update_pulse}, 8'h03);
      tick1();
      chk("R11 miss", {6'd0, alarm_pulse, update_pulse}, 8'h01);
      wr(A_ASEC, 8'h00); wr(A_AMIN, 8'h10); wr(A_AHR, 8'h05);
      set_hms(8'h05, 8'h09, 8'h59);
      tick1();
      chk("R11 exact hit", {7'd0, alarm_pulse}, 8'h01);
      wr(A_AHR, 8'h06);
      set_hms(8'h05, 8'h09, 8'h59);
      tick1();
      chk("R11 hour mismatch", {7'd0, alarm_pulse}, 8'h00);
   endtask

   task automatic t_dst();
      wr(A_WDAY, 8'h01);
      set_dmy(8'h05, 8'h04, 8'h24);
      set_hms(8'h01, 8'h59, 8'h59);
      tick1();
      chk_reg("R12 dst off", A_HR, 8'h02);
      cfg_dst = 1'b1;
      set_hms(8'h01, 8'h59, 8'h59);
      tick1();
      chk_reg("R12 spring hour", A_HR, 8'h03);
      chk_reg("R12 spring min", A_MIN, 8'h00);
      set_dmy(8'h26, 8'h10, 8'h24);
      set_hms(8'h01, 8'h59, 8'h59);
      tick1();
      chk_reg("R12 fall back", A_HR, 8'h01);
      chk_reg("R12 fall min", A_MIN, 8'h00);
      wr(A_MIN, 8'h59); wr(A_SEC, 8'h59);
      tick1();
      chk_reg("R12 fall once", A_HR, 8'h02);
      cfg_dst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bcd_roll();
      t_binary();
      t_12h();
      t_calendar();
      t_set_freeze();
      t_sec_ro();
      t_collision();
      t_alarm();
      t_dst();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule